// File: doc/BRIEF.md
# Programmable Lane Bit Mapper for a 7-bit Serial Display Link

This block turns one pixel per clock into five parallel 7-bit lane words for a 7:1 serial display link. A pixel is 24-bit colour plus horizontal sync, vertical sync, data enable and one spare control bit. Every one of the 35 output bit positions has its own 5-bit source selector. Each selector picks one colour bit, one of the sync/enable/control bits, or a constant. Because of this, any lane packing can be programmed.

Two packings are built in and can be loaded in one cycle. The high packing puts the upper six bits of each colour on lanes 1 to 3 and the two low bits on lane 4. The low packing puts the lower six bits on lanes 1 to 3 and the two top bits on lane 4. Both packings drive lane 0 with the fixed clock pattern. Before mapping, the sync and enable bits can be inverted one by one, and a global enable forces all lanes to zero while it is low.

An optional shift stage sends each lane word out serially, least significant bit first, as 7-cycle frames. The 7:1 serializer itself is not part of this block.

Top module: `lane_bit_mapper`

## Requirements
- R1: Bit k of lane l appears on `lane_words[l*7+k]`, and bit 0 is the first bit in transmission order. The lane words are registered: they reflect the pixel inputs and configuration present at the previous rising clock edge, so a pixel change shows up one cycle later.
- R2: The selector codes are:
  - 0-7: red bits 0-7
  - 8-15: green bits 0-15 minus 8, that is green bits 0-7
  - 16-23: blue bits 0-7
  - 24: horizontal sync (after any inversion)
  - 25: vertical sync (after any inversion)
  - 26: data enable (after any inversion)
  - 27: control bit
  - 28: constant 0
  - 29: constant 1
  - 30 and 31: output 0
- R3: Selector registers sit at byte addresses based on the lane number l (0 to 4):
  - 0x04+8*l holds the selectors for positions 0, 1, 2 and 3, in write-data fields [4:0], [9:5], [14:10] and [19:15].
  - 0x08+8*l holds the selectors for positions 4, 5 and 6, in fields [4:0], [9:5] and [14:10].
- R4: The control register is at address 0x00. Its bits are:
  - bit 0: output enable
  - bit 1: inverts horizontal sync
  - bit 2: inverts vertical sync
  - bit 3: inverts data enable

  The inversion is applied before the selectors pick their bits.
- R5: While the output enable is 0, every lane word is 0, whatever the pixel inputs or the selectors hold.
- R6: A pulse on `preset_load` loads a built-in packing into all 35 selectors. `preset_sel` picks the packing: 0 is the high packing and 1 is the low packing.
  - Lane 0, bit 6 down to bit 0, is 1,1,0,0,0,1,1 (0x63) in both packings.
  - High packing, bit 6 down to bit 0: lane 1 = G2,R7..R2; lane 2 = B3,B2,G7..G3; lane 3 = DE,VS,HS,B7..B4; lane 4 = CE,B1,B0,G1,G0,R1,R0.
  - Low packing, bit 6 down to bit 0: lane 1 = G0,R5..R0; lane 2 = B1,B0,G5..G1; lane 3 = DE,VS,HS,B5..B2; lane 4 = CE,B7,B6,G7,G6,R7,R6.
- R7: After reset the control register is 0 and the selectors hold the high packing.
- R8: If `preset_load` and a selector-register write happen in the same cycle, the preset wins and the write is lost.
- R9: A write to any address not listed in R3 or R4 changes neither the selectors nor the control register. This includes misaligned addresses and addresses past the last lane.
- R10: With the shift stage enabled, a word is loaded from `lane_words` every 7 cycles. `ser_first` is high in the cycle that shows bit 0. `ser_data[l]` then shows bits 0 to 6 of lane l on seven consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (8) | Register byte address |
| cfg_wdata | input | DATA_W (32) | Register write data |
| preset_load | input | 1 | Load a built-in packing into all selectors |
| preset_sel | input | 1 | Packing to load: 0 high, 1 low |
| pix_r | input | COLOR_W (8) | Red component |
| pix_g | input | COLOR_W (8) | Green component |
| pix_b | input | COLOR_W (8) | Blue component |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| pix_ce | input | 1 | Spare control bit |
| lane_words | output | LANES*WORD_BITS (35) | Parallel lane words, lane l at [l*7 +: 7] |
| ser_data | output | LANES (5) | Serial bit per lane, LSB first |
| ser_first | output | 1 | Marks the cycle carrying bit 0 of a frame |

## Verification
The hardest state to reach from the ports is a preset load that coincides with a selector write. The coinciding write must also leave a pattern that the stimulus can tell apart from the preset. The bench drives both strobes in the same cycle, writing codes that select red bit 0 on lane 1. It then applies a pixel on which this all-zero-code write and the low packing give different lane-1 words.

Frame alignment of the shift stage is free-running and cannot be set from outside. The bench therefore holds one pixel steady, waits for the frame marker, and rebuilds each lane word from seven consecutive serial samples. A hand-computed vector table covers both packings and each inversion bit. Address spacing, misaligned writes and out-of-range writes are tested through the output they could have disturbed.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

   localparam int SEL_W     = 5;
   localparam int STD_LANES = 5;
   localparam int STD_BITS  = 7;
   localparam int LO_SLOTS  = 4;

   // source codes (R2)
   localparam int SRC_R0   = 0;
   localparam int SRC_G0   = 8;
   localparam int SRC_B0   = 16;
   localparam int SRC_HS   = 24;
   localparam int SRC_VS   = 25;
   localparam int SRC_DE   = 26;
   localparam int SRC_CE   = 27;
   localparam int SRC_ZERO = 28;
   localparam int SRC_ONE  = 29;

   // register layout (R3, R4)
   localparam int CTRL_ADDR   = 0;
   localparam int LO_BASE     = 4;
   localparam int HI_BASE     = 8;
   localparam int LANE_STRIDE = 8;

   typedef enum logic {PK_HIGH = 1'b0, PK_LOW = 1'b1} pack_e;

   typedef struct packed {
      logic inv_de;
      logic inv_vs;
      logic inv_hs;
      logic out_en;
   } ctrl_t;

   function automatic logic [SEL_W-1:0] preset_code(input pack_e pk, input int lane, input int pos);
      int v;
      bit hi;
      hi = (pk == PK_HIGH);
      v  = SRC_ZERO;
      case (lane)
         0: v = (pos >= 2 && pos <= 4) ? SRC_ZERO : SRC_ONE;
         1: v = (pos == 6) ? SRC_G0 + (hi ? 2 : 0) : SRC_R0 + pos + (hi ? 2 : 0);
         2: v = (pos >= 5) ? SRC_B0 + pos - 5 + (hi ? 2 : 0) : SRC_G0 + pos + (hi ? 3 : 1);
         3: begin
            case (pos)
               6:       v = SRC_DE;
               5:       v = SRC_VS;
               4:       v = SRC_HS;
               default: v = SRC_B0 + pos + (hi ? 4 : 2);
            endcase
         end
         4: begin
            if (pos == 6)      v = SRC_CE;
            else if (pos >= 4) v = SRC_B0 + pos - 4 + (hi ? 0 : 6);
            else if (pos >= 2) v = SRC_G0 + pos - 2 + (hi ? 0 : 6);
            else               v = SRC_R0 + pos + (hi ? 0 : 6);
         end
         default: v = SRC_ZERO;
      endcase
      return SEL_W'(v);
   endfunction

   function automatic logic [STD_LANES*STD_BITS*SEL_W-1:0] preset_flat(input pack_e pk);
      logic [STD_LANES*STD_BITS*SEL_W-1:0] f;
      f = '0;
      for (int l = 0; l < STD_LANES; l++) begin
         for (int p = 0; p < STD_BITS; p++) begin
            f[(l*STD_BITS+p)*SEL_W +: SEL_W] = preset_code(pk, l, p);
         end
      end
      return f;
   endfunction

endpackage

// File: rtl/lbm_sel_regs.sv
module lbm_sel_regs
   import lbm_pkg::*;
#(
   parameter int LANES     = 5,
   parameter int WORD_BITS = 7,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic                            preset_load,
   input  logic                            preset_sel,
   output ctrl_t                           ctrl_q,
   output logic [LANES*WORD_BITS*SEL_W-1:0] sel_q
);
   localparam int USED_W   = LO_SLOTS * SEL_W;
   localparam int LAST_ADR = HI_BASE + (LANES - 1) * LANE_STRIDE;

   if (DATA_W < USED_W) begin : g_bad_data
      $error("lbm_sel_regs: DATA_W too small for four selector fields");
   end
   if ((1 << ADDR_W) <= LAST_ADR) begin : g_bad_addr
      $error("lbm_sel_regs: ADDR_W cannot reach the last lane register");
   end
   if (WORD_BITS <= LO_SLOTS) begin : g_bad_bits
      $error("lbm_sel_regs: WORD_BITS must exceed the low-register slot count");
   end

   if (DATA_W > USED_W) begin : g_spare
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wr_data[DATA_W-1:USED_W];
   end

   // control register (R4)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) begin
         ctrl_q <= ctrl_t'(wr_data[3:0]);
      end
   end

   // per-position selector (R3, R6, R7, R8)
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      for (genvar p = 0; p < WORD_BITS; p++) begin : g_pos
         localparam int REG_OFS = (p < LO_SLOTS) ? LO_BASE + l * LANE_STRIDE
                                                 : HI_BASE + l * LANE_STRIDE;
         localparam int FLD     = (p < LO_SLOTS) ? p * SEL_W : (p - LO_SLOTS) * SEL_W;
         localparam int IDX     = (l * WORD_BITS + p) * SEL_W;
         logic hit;
         assign hit = wr_en && (wr_addr == ADDR_W'(REG_OFS));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sel_q[IDX +: SEL_W] <= preset_code(PK_HIGH, l, p);
            end else if (preset_load) begin
               sel_q[IDX +: SEL_W] <= preset_code(pack_e'(preset_sel), l, p);
            end else if (hit) begin
               sel_q[IDX +: SEL_W] <= wr_data[FLD +: SEL_W];
            end
         end
      end
   end

endmodule

// File: rtl/lbm_src_build.sv
module lbm_src_build
   import lbm_pkg::*;
#(
   parameter int COLOR_W = 8,
   localparam int SRC_N  = 1 << SEL_W
) (
   input  logic [COLOR_W-1:0] pix_r,
   input  logic [COLOR_W-1:0] pix_g,
   input  logic [COLOR_W-1:0] pix_b,
   input  logic               pix_hs,
   input  logic               pix_vs,
   input  logic               pix_de,
   input  logic               pix_ce,
   input  ctrl_t              ctrl,
   output logic [SRC_N-1:0]   src
);
   if (COLOR_W != SRC_G0) begin : g_bad_color
      $error("lbm_src_build: code map assumes COLOR_W == 8");
   end

   always_comb begin
      src                          = '0;
      src[SRC_R0 +: COLOR_W]       = pix_r;
      src[SRC_G0 +: COLOR_W]       = pix_g;
      src[SRC_B0 +: COLOR_W]       = pix_b;
      src[SRC_HS]                  = pix_hs ^ ctrl.inv_hs;
      src[SRC_VS]                  = pix_vs ^ ctrl.inv_vs;
      src[SRC_DE]                  = pix_de ^ ctrl.inv_de;
      src[SRC_CE]                  = pix_ce;
      src[SRC_ZERO]                = 1'b0;
      src[SRC_ONE]                 = 1'b1;
   end

   logic unused_en;
   assign unused_en = ctrl.out_en;

endmodule

// File: rtl/lbm_lane_mux.sv
module lbm_lane_mux
   import lbm_pkg::*;
#(
   parameter int LANES     = 5,
   parameter int WORD_BITS = 7,
   localparam int SRC_N    = 1 << SEL_W,
   localparam int NPOS     = LANES * WORD_BITS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    out_en,
   input  logic [SRC_N-1:0]        src,
   input  logic [NPOS*SEL_W-1:0]   sel,
   output logic [NPOS-1:0]         words
);
   logic [NPOS-1:0] nxt;

   for (genvar i = 0; i < NPOS; i++) begin : g_bit
      assign nxt[i] = src[sel[i*SEL_W +: SEL_W]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      words <= '0;
      else if (out_en) words <= nxt;
      else             words <= '0;
   end

endmodule

// File: rtl/lbm_shift_out.sv
module lbm_shift_out #(
   parameter int LANES     = 5,
   parameter int WORD_BITS = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LANES*WORD_BITS-1:0] words,
   output logic [LANES-1:0]           ser_data,
   output logic                       ser_first
);
   localparam int PH_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_BITS - 1);

   logic [PH_W-1:0] ph_q;
   logic            load;

   assign load = (ph_q == PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= PH_LAST;
         ser_first <= 1'b0;
      end else if (load) begin
         ph_q      <= '0;
         ser_first <= 1'b1;
      end else begin
         ph_q      <= ph_q + PH_W'(1);
         ser_first <= 1'b0;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [WORD_BITS-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    sh_q <= '0;
         else if (load) sh_q <= words[l*WORD_BITS +: WORD_BITS];
         else           sh_q <= sh_q >> 1;
      end
      assign ser_data[l] = sh_q[0];
   end

endmodule

// File: rtl/lane_bit_mapper.sv
module lane_bit_mapper
   import lbm_pkg::*;
#(
   parameter int LANES     = 5,
   parameter int WORD_BITS = 7,
   parameter int COLOR_W   = 8,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter bit SHIFT_EN  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_wr,
   input  logic [ADDR_W-1:0]          cfg_addr,
   input  logic [DATA_W-1:0]          cfg_wdata,
   input  logic                       preset_load,
   input  logic                       preset_sel,
   input  logic [COLOR_W-1:0]         pix_r,
   input  logic [COLOR_W-1:0]         pix_g,
   input  logic [COLOR_W-1:0]         pix_b,
   input  logic                       pix_hs,
   input  logic                       pix_vs,
   input  logic                       pix_de,
   input  logic                       pix_ce,
   output logic [LANES*WORD_BITS-1:0] lane_words,
   output logic [LANES-1:0]           ser_data,
   output logic                       ser_first
);
   localparam int SRC_N = 1 << SEL_W;
   localparam int NPOS  = LANES * WORD_BITS;

   if (LANES != STD_LANES || WORD_BITS != STD_BITS) begin : g_bad_geom
      $error("lane_bit_mapper: built-in packings need 5 lanes of 7 bits");
   end
   if (3 * COLOR_W + 6 > SRC_N) begin : g_bad_src
      $error("lane_bit_mapper: source vector exceeds selector range");
   end

   ctrl_t                  ctrl_q;
   logic [NPOS*SEL_W-1:0]  sel_q;
   logic [SRC_N-1:0]       src;

   lbm_sel_regs #(
      .LANES(LANES), .WORD_BITS(WORD_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr),
      .wr_data(cfg_wdata), .preset_load(preset_load), .preset_sel(preset_sel),
      .ctrl_q(ctrl_q), .sel_q(sel_q)
   );

   lbm_src_build #(.COLOR_W(COLOR_W)) u_src (
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_hs(pix_hs),
      .pix_vs(pix_vs), .pix_de(pix_de), .pix_ce(pix_ce), .ctrl(ctrl_q),
      .src(src)
   );

   lbm_lane_mux #(.LANES(LANES), .WORD_BITS(WORD_BITS)) u_mux (
      .clk(clk), .rst_n(rst_n), .out_en(ctrl_q.out_en), .src(src),
      .sel(sel_q), .words(lane_words)
   );

   if (SHIFT_EN) begin : g_shift
      lbm_shift_out #(.LANES(LANES), .WORD_BITS(WORD_BITS)) u_shift (
         .clk(clk), .rst_n(rst_n), .words(lane_words),
         .ser_data(ser_data), .ser_first(ser_first)
      );
   end else begin : g_no_shift
      assign ser_data  = '0;
      assign ser_first = 1'b0;
   end

endmodule

// File: rtl/lbm_checker.sv
module lbm_checker
   import lbm_pkg::*;
#(
   parameter int LANES     = 5,
   parameter int WORD_BITS = 7,
   parameter int COLOR_W   = 8,
   parameter int ADDR_W    = 8,
   parameter bit SHIFT_EN  = 1'b1
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             cfg_wr,
   input logic [ADDR_W-1:0]                cfg_addr,
   input logic                             preset_load,
   input logic                             preset_sel,
   input logic [COLOR_W-1:0]               pix_r,
   input logic [COLOR_W-1:0]               pix_g,
   input logic [COLOR_W-1:0]               pix_b,
   input logic                             pix_hs,
   input logic                             pix_vs,
   input logic                             pix_de,
   input logic                             pix_ce,
   input logic [3:0]                       ctrl_q,
   input logic [LANES*WORD_BITS*SEL_W-1:0] sel_q,
   input logic [LANES*WORD_BITS-1:0]       lane_words,
   input logic [LANES-1:0]                 ser_data,
   input logic                             ser_first
);
   logic addr_known;
   always_comb begin
      addr_known = (cfg_addr == ADDR_W'(CTRL_ADDR));
      for (int l = 0; l < LANES; l++) begin
         if (cfg_addr == ADDR_W'(LO_BASE + l * LANE_STRIDE) ||
             cfg_addr == ADDR_W'(HI_BASE + l * LANE_STRIDE))
            addr_known = 1'b1;
      end
   end

   // R5: disabled output gives all-zero lanes next cycle
   p_idle_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[0] |=> (lane_words == '0));

   // R1: unchanged inputs and configuration keep the lanes unchanged
   p_hold_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable({pix_r, pix_g, pix_b, pix_hs, pix_vs, pix_de, pix_ce}) &&
       $stable(sel_q) && $stable(ctrl_q)) |=> $stable(lane_words));

   // R8, R6: a preset load always lands, whatever else is written
   p_preset_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      preset_load |=> (sel_q == preset_flat(pack_e'($past(preset_sel)))));

   // R9: writes to unmapped addresses leave configuration alone
   p_ignore_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !addr_known && !preset_load) |=> ($stable(sel_q) && $stable(ctrl_q)));

   if (SHIFT_EN) begin : g_ser
      logic [LANES-1:0] bit0;
      logic [7:0]       gap_q;
      logic             seen_q;

      for (genvar l = 0; l < LANES; l++) begin : g_b0
         assign bit0[l] = lane_words[l*WORD_BITS];
      end

      // R10: frame start shows bit 0 of the word present at load
      p_first_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
         ser_first |-> (ser_data == $past(bit0)));

      p_marker_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
         ser_first |=> !ser_first);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
         end else if (ser_first) begin
            a_frame_len_r10: assert (!seen_q || gap_q == 8'(WORD_BITS - 1))
               else $error("frame length differs from word width");
            gap_q  <= '0;
            seen_q <= 1'b1;
         end else begin
            gap_q  <= gap_q + 8'd1;
         end
      end
   end else begin : g_no_ser
      logic unused_ser;
      assign unused_ser = ^{ser_data, ser_first};
   end

endmodule

bind lane_bit_mapper lbm_checker #(
   .LANES(LANES), .WORD_BITS(WORD_BITS), .COLOR_W(COLOR_W),
   .ADDR_W(ADDR_W), .SHIFT_EN(SHIFT_EN)
) u_lbm_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
   .preset_load(preset_load), .preset_sel(preset_sel),
   .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_hs(pix_hs),
   .pix_vs(pix_vs), .pix_de(pix_de), .pix_ce(pix_ce),
   .ctrl_q(ctrl_q), .sel_q(sel_q), .lane_words(lane_words),
   .ser_data(ser_data), .ser_first(ser_first)
);

// File: tb/tb_lane_bit_mapper.sv
module tb_lane_bit_mapper;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        preset_load = 1'b0;
   logic        preset_sel = 1'b0;
   logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
   logic        pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0, pix_ce = 1'b0;
   logic [34:0] lane_words;
   logic [4:0]  ser_data;
   logic        ser_first;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   lane_bit_mapper dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .preset_load(preset_load), .preset_sel(preset_sel),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_hs(pix_hs),
      .pix_vs(pix_vs), .pix_de(pix_de), .pix_ce(pix_ce),
      .lane_words(lane_words), .ser_data(ser_data), .ser_first(ser_first)
   );

   typedef struct packed {
      logic       pk;
      logic [3:0] ctrl;
      logic [7:0] r, g, b;
      logic       hs, vs, de, ce;
      logic [6:0] l4, l3, l2, l1, l0;
   } vec_t;

   localparam int NVEC = 15;
   localparam vec_t VECS [NVEC] = '{
      // high packing (R6), enable on
      '{1'b0, 4'h1, 8'hFF, 8'h00, 8'h00, 1'b0,1'b0,1'b0,1'b0, 7'h03,7'h00,7'h00,7'h3F,7'h63},
      '{1'b0, 4'h1, 8'h00, 8'hFF, 8'h00, 1'b0,1'b0,1'b0,1'b0, 7'h0C,7'h00,7'h1F,7'h40,7'h63},
      '{1'b0, 4'h1, 8'h00, 8'h00, 8'hFF, 1'b0,1'b0,1'b0,1'b0, 7'h30,7'h0F,7'h60,7'h00,7'h63},
      '{1'b0, 4'h1, 8'h00, 8'h00, 8'h00, 1'b1,1'b1,1'b1,1'b1, 7'h40,7'h70,7'h00,7'h00,7'h63},
      '{1'b0, 4'h1, 8'h81, 8'h00, 8'h00, 1'b0,1'b0,1'b0,1'b0, 7'h01,7'h00,7'h00,7'h20,7'h63},
      // inversion (R4)
      '{1'b0, 4'h3, 8'h00, 8'h00, 8'h00, 1'b0,1'b0,1'b0,1'b0, 7'h00,7'h10,7'h00,7'h00,7'h63},
      '{1'b0, 4'hF, 8'h00, 8'h00, 8'h00, 1'b0,1'b0,1'b0,1'b0, 7'h00,7'h70,7'h00,7'h00,7'h63},
      '{1'b0, 4'hF, 8'h00, 8'h00, 8'h00, 1'b1,1'b1,1'b1,1'b0, 7'h00,7'h00,7'h00,7'h00,7'h63},
      // disabled (R5)
      '{1'b0, 4'h0, 8'hFF, 8'hFF, 8'hFF, 1'b1,1'b1,1'b1,1'b1, 7'h00,7'h00,7'h00,7'h00,7'h00},
      // low packing (R6)
      '{1'b1, 4'h1, 8'h03, 8'h00, 8'h00, 1'b0,1'b0,1'b0,1'b0, 7'h00,7'h00,7'h00,7'h03,7'h63},
      '{1'b1, 4'h1, 8'h00, 8'h01, 8'h00, 1'b0,1'b0,1'b0,1'b0, 7'h00,7'h00,7'h00,7'h40,7'h63},
      '{1'b1, 4'h1, 8'h00, 8'h00, 8'h80, 1'b0,1'b0,1'b0,1'b0, 7'h20,7'h00,7'h00,7'h00,7'h63},
      '{1'b1, 4'h1, 8'h00, 8'h00, 8'h03, 1'b0,1'b0,1'b0,1'b0, 7'h00,7'h00,7'h60,7'h00,7'h63},
      '{1'b1, 4'h1, 8'h00, 8'h00, 8'h00, 1'b1,1'b1,1'b1,1'b1, 7'h40,7'h70,7'h00,7'h00,7'h63},
      '{1'b1, 4'h1, 8'hFF, 8'hFF, 8'hFF, 1'b0,1'b0,1'b0,1'b0, 7'h3F,7'h0F,7'h7F,7'h7F,7'h63}
   };

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic load_preset(input logic pk);
      @(negedge clk);
      preset_load = 1'b1; preset_sel = pk;
      @(negedge clk);
      preset_load = 1'b0;
   endtask

   task automatic set_pix(input logic [7:0] r, g, b, input logic hs, vs, de, ce);
      pix_r = r; pix_g = g; pix_b = b;
      pix_hs = hs; pix_vs = vs; pix_de = de; pix_ce = ce;
   endtask

   function automatic logic [6:0] lane(input int l);
      return lane_words[l*7 +: 7];
   endfunction

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic cur_pk;
      logic [6:0] w [5];
      // reset state (R7)
      repeat (3) @(negedge clk);
      check("R7 lanes in reset", 64'(lane_words), 64'h0);
      check("R7 ser_first in reset", 64'(ser_first), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 lanes after reset, output disabled", 64'(lane_words), 64'h0);

      // reset selectors hold the high packing (R7)
      cfg_write(8'h00, 32'h1);
      set_pix(8'hFF, 8'h00, 8'h00, 0, 0, 0, 0);
      @(negedge clk);
      check("R7 reset packing, red full", 64'(lane_words),
            64'({7'h03, 7'h00, 7'h00, 7'h3F, 7'h63}));

      // one-cycle latency (R1)
      set_pix(8'h00, 8'hFF, 8'h00, 0, 0, 0, 0);
      #1;
      check("R1 lanes unchanged before the edge", 64'(lane_words),
            64'({7'h03, 7'h00, 7'h00, 7'h3F, 7'h63}));
      @(negedge clk);
      check("R1 lanes after one edge", 64'(lane_words),
            64'({7'h0C, 7'h00, 7'h1F, 7'h40, 7'h63}));

      // vector table (R4, R5, R6)
      cur_pk = 1'b0;
      for (int i = 0; i < NVEC; i++) begin
         if (VECS[i].pk != cur_pk) begin
            load_preset(VECS[i].pk);
            cur_pk = VECS[i].pk;
         end
         cfg_write(8'h00, 32'(VECS[i].ctrl));
         set_pix(VECS[i].r, VECS[i].g, VECS[i].b,
                 VECS[i].hs, VECS[i].vs, VECS[i].de, VECS[i].ce);
         @(negedge clk);
         check($sformatf("R6/R4/R5 table entry %0d", i), 64'(lane_words),
               64'({VECS[i].l4, VECS[i].l3, VECS[i].l2, VECS[i].l1, VECS[i].l0}));
      end

      // custom selectors, high packing base (R2, R3)
      load_preset(1'b0);
      cfg_write(8'h00, 32'h1);
      cfg_write(8'h0C, 32'd29 | (32'd28 << 5) | (32'd27 << 10) | (32'd24 << 15));
      cfg_write(8'h10, 32'd30 | (32'd31 << 5) | (32'd26 << 10));
      set_pix(8'h00, 8'h00, 8'h00, 1, 0, 0, 1);
      @(negedge clk);
      check("R2 lane1 const1/const0/ctl/hs/unused codes", 64'(lane(1)), 64'h0D);
      set_pix(8'h00, 8'h00, 8'h00, 1, 0, 1, 1);
      @(negedge clk);
      check("R2 lane1 data-enable code in pos6", 64'(lane(1)), 64'h4D);
      check("R3 lane0 untouched by lane1 writes", 64'(lane(0)), 64'h63);

      cfg_write(8'h14, 32'd7);
      set_pix(8'h80, 8'h00, 8'h00, 1, 0, 1, 1);
      @(negedge clk);
      check("R3 lane2 low register at 0x14", 64'(lane(2)), 64'h01);
      set_pix(8'h81, 8'h00, 8'h00, 1, 0, 1, 1);
      @(negedge clk);
      check("R3 lane2 positions 1..3 select red0", 64'(lane(2)), 64'h0F);

      // ignored writes (R9)
      cfg_write(8'h01, 32'h0);
      cfg_write(8'h0D, 32'h0);
      cfg_write(8'h2C, 32'h0);
      cfg_write(8'hF0, 32'h0);
      set_pix(8'h00, 8'h00, 8'h00, 1, 0, 1, 1);
      @(negedge clk);
      check("R9 lane1 after unmapped writes", 64'(lane(1)), 64'h4D);
      check("R9 output still enabled", 64'(lane(0)), 64'h63);

      // preset beats coinciding write (R8)
      @(negedge clk);
      preset_load = 1'b1; preset_sel = 1'b1;
      cfg_wr = 1'b1; cfg_addr = 8'h0C; cfg_wdata = 32'h0;
      @(negedge clk);
      preset_load = 1'b0; cfg_wr = 1'b0;
      set_pix(8'h03, 8'h00, 8'h00, 0, 0, 0, 0);
      @(negedge clk);
      check("R8 lane1 follows low packing", 64'(lane(1)), 64'h03);
      check("R8 lane4 follows low packing", 64'(lane(4)), 64'h00);

      // shift-out (R10)
      load_preset(1'b0);
      set_pix(8'hFF, 8'h00, 8'h00, 0, 0, 0, 0);
      repeat (10) @(negedge clk);
      for (int k = 0; k < 20 && !ser_first; k++) @(negedge clk);
      check("R10 frame marker found", 64'(ser_first), 64'h1);
      for (int l = 0; l < 5; l++) w[l] = '0;
      for (int b = 0; b < 7; b++) begin
         for (int l = 0; l < 5; l++) w[l][b] = ser_data[l];
         if (b > 0) check($sformatf("R10 marker low at bit %0d", b), 64'(ser_first), 64'h0);
         @(negedge clk);
      end
      check("R10 marker returns after 7 cycles", 64'(ser_first), 64'h1);
      check("R10 serial lane words LSB first", 64'({w[4], w[3], w[2], w[1], w[0]}),
            64'({7'h03, 7'h00, 7'h00, 7'h3F, 7'h63}));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule